// File: doc/BRIEF.md
# Channel Output Test Pattern Multiplexer

This block chooses, once per bunch crossing, the word that goes to the output link of a group of channels. It carries 8 bits for each of 32 channels. The source is one of five: the processed channel results, a programmed constant, a pseudo-random stream from a 23-bit maximal-length shift register, a sequence of words loaded earlier into a playback memory, or the raw samples captured at the most recent level-1 accept. The crossing strobe marks each boundary. The output register and the mode in force change only at that edge, so every output word comes from one source.

Every word sent is also written into a circular history buffer. Monitoring software can freeze this buffer and read it back by age, counted from the newest entry. A simple register port carries the mode, the constant, the seed, the freeze bit and the playback start command. The same port loads the playback memory and reads back all stored state.

The register map uses the two top address bits as a region: 0 = control and status, 1 = playback memory, 2 = history, 3 = raw capture. In the control region, word 0 is the control register, word 1 is the constant and word 2 is the seed. In the control register, bits [2:0] hold the mode, bit 8 is freeze and bit 9 is start, which is a write-only strobe. In the playback and history regions, address offset n*8+w holds entry n, 32-bit word w. Word w carries channels 4w to 4w+3, with channel 4w in bits [7:0]. On the output bus, channel c occupies bits [8c+7:8c].

Top module: `link_pattern_mux`

## Requirements
- R1: After reset the output is zero. The control register and the constant read 0, and the seed reads 0x7FFFFF. Every playback and history word reads 0.
- R2: The output changes only in the cycle after a clock edge at which bx_i is high. Between crossings it holds its value, and each word is taken whole from the mode in force before that edge.
- R3: Mode 0, and the unused codes 5, 6 and 7, forward data_i as sampled at the crossing edge.
- R4: Mode 1 puts the 8-bit constant (control word 1, bits [7:0]) on every channel.
- R5: In mode 2, bit b of channel c equals shift-register bit (3c+b) mod 23. After each mode-2 crossing the register shifts left by one, and the new bit 0 is bit 22 XOR bit 17. Writing a non-zero seed (word 2, bits [22:0]) loads the register, and this load wins over a shift at the same edge. A zero seed is ignored. Reading word 2 returns the current register.
- R6: Mode 3 sends playback entries in order, wrapping after 16 entries. The pointer advances only on mode-3 crossings. A register read of the playback region returns the stored word.
- R7: Writing control bit 9 resets the playback pointer, so the next mode-3 crossing sends entry 0.
- R8: Every crossing's output word is written into the 16-entry history. A read at history offset a*8+w returns word w of the entry sent a crossings before the newest.
- R9: While control bit 8 is set, crossings after the write that set it are not recorded, and history reads stay fixed. Clearing the bit resumes recording.
- R10: A crossing with l1a_i high captures raw_i, 10 bits per channel. Raw region word c reads channel c, zero-extended. Mode 4 sends bits [9:2] of each captured channel.
- R11: reg_rdata_o shows, one cycle later, the word addressed at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bx_i | input | 1 | Crossing boundary strobe |
| l1a_i | input | 1 | Level-1 accept, sampled with bx_i |
| data_i | input | 256 | Processed channel data, 8 bits per channel |
| raw_i | input | 320 | Raw samples, 10 bits per channel |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 10 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| link_data_o | output | 256 | Word sent to the output link |

## Verification
The hardest cases to reach are register writes that land on the same edge as a crossing. Examples are a mode change, a start command, a seed load or a freeze arriving exactly when a word is being selected, where ordering decides which value wins. The stimulus runs a free crossing generator with random gaps of zero to three cycles, including back-to-back crossings, while register writes proceed on their own schedule. These collisions therefore occur many times, and a cycle-accurate behavioural model resolves each one. The history is read back in full both while frozen and while it is still moving, and the playback sequence is run past its wrap point, both with and without restart.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;
  localparam int REG_W = 32;

  localparam logic [2:0] M_NORM  = 3'd0;
  localparam logic [2:0] M_CONST = 3'd1;
  localparam logic [2:0] M_PRBS  = 3'd2;
  localparam logic [2:0] M_PLAY  = 3'd3;
  localparam logic [2:0] M_RAW   = 3'd4;

  localparam logic [1:0] RG_CSR  = 2'd0;
  localparam logic [1:0] RG_PLAY = 2'd1;
  localparam logic [1:0] RG_HIST = 2'd2;
  localparam logic [1:0] RG_RAW  = 2'd3;

  localparam int CSR_CTRL  = 0;
  localparam int CSR_CONST = 1;
  localparam int CSR_SEED  = 2;

  localparam int CTRL_FRZ_BIT   = 8;
  localparam int CTRL_START_BIT = 9;
endpackage

// File: rtl/lpm_prbs.sv
`timescale 1ns/1ps
module lpm_prbs #(
  parameter int NUM_CH     = 32,
  parameter int CH_W       = 8,
  parameter int LFSR_W     = 23,
  parameter int TAP        = 18,
  parameter int SLICE_STEP = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     seed_we_i,
  input  logic [LFSR_W-1:0]        seed_i,
  input  logic                     adv_i,
  output logic [LFSR_W-1:0]        state_o,
  output logic [NUM_CH*CH_W-1:0]   word_o
);
  logic [LFSR_W-1:0] st_q;
  logic              fb;

  assign fb = st_q[LFSR_W-1] ^ st_q[TAP-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             st_q <= '1;
    else if (seed_we_i && (seed_i != '0))    st_q <= seed_i;
    else if (adv_i)                          st_q <= {st_q[LFSR_W-2:0], fb};
  end

  assign state_o = st_q;

  // each channel slice starts at a different offset into the state
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar b = 0; b < CH_W; b++) begin : g_bit
      assign word_o[c*CH_W+b] = st_q[(c*SLICE_STEP+b) % LFSR_W];
    end
  end

  a_r5_state_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != '0);
  a_r5_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seed_we_i && !adv_i |=> $stable(st_q));
  a_r5_zero_seed_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_we_i && (seed_i == '0) && !adv_i |=> $stable(st_q));
endmodule

// File: rtl/lpm_playback.sv
`timescale 1ns/1ps
module lpm_playback #(
  parameter int ENT_W = 256,
  parameter int DEPTH = 16,
  parameter int REG_W = 32,
  localparam int WPC   = ENT_W / REG_W,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int WS_W  = $clog2(WPC),
  localparam int AW    = PTR_W + WS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              start_i,
  input  logic              adv_i,
  output logic [ENT_W-1:0]  ent_o
);
  logic [DEPTH-1:0][WPC-1:0][REG_W-1:0] mem_q;
  logic [PTR_W-1:0]                     ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      ptr_q <= '0;
    end else begin
      if (wr_i) mem_q[wr_addr_i[AW-1:WS_W]][wr_addr_i[WS_W-1:0]] <= wr_data_i;
      if (start_i)    ptr_q <= '0;
      else if (adv_i) ptr_q <= ptr_q + PTR_W'(1);  // power-of-two depth wraps
    end
  end

  assign ent_o     = mem_q[ptr_q];
  assign rd_data_o = mem_q[rd_addr_i[AW-1:WS_W]][rd_addr_i[WS_W-1:0]];

  a_r6_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !start_i |=> ptr_q == $past(ptr_q) + PTR_W'(1));
  a_r6_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !start_i |=> $stable(ptr_q));
  a_r7_start_entry0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ent_o == $past(mem_q[0]) || $past(wr_i));
endmodule

// File: rtl/lpm_history.sv
`timescale 1ns/1ps
module lpm_history #(
  parameter int ENT_W = 256,
  parameter int DEPTH = 16,
  parameter int REG_W = 32,
  localparam int WPC   = ENT_W / REG_W,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int WS_W  = $clog2(WPC),
  localparam int AW    = PTR_W + WS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ENT_W-1:0]  ent_i,
  input  logic              freeze_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o
);
  logic [DEPTH-1:0][WPC-1:0][REG_W-1:0] hist_q;
  logic [PTR_W-1:0]                     wp_q;
  logic [PTR_W-1:0]                     slot;
  logic                                 wr_en;

  assign wr_en = push_i && !freeze_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      wp_q   <= '0;
    end else if (wr_en) begin
      hist_q[wp_q] <= ent_i;
      wp_q         <= wp_q + PTR_W'(1);
    end
  end

  // age 0 is the newest entry
  assign slot      = wp_q - PTR_W'(1) - rd_addr_i[AW-1:WS_W];
  assign rd_data_o = hist_q[slot][rd_addr_i[WS_W-1:0]];

  a_r9_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(wp_q) && $stable(hist_q));
  a_r8_wp_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !freeze_i |=> wp_q == $past(wp_q) + PTR_W'(1));
  a_r8_newest_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !freeze_i |=> hist_q[wp_q - PTR_W'(1)] == $past(ent_i));
endmodule

// File: rtl/link_pattern_mux.sv
`timescale 1ns/1ps
module link_pattern_mux
  import lpm_pkg::*;
#(
  parameter int NUM_CH     = 32,
  parameter int CH_W       = 8,
  parameter int RAW_W      = 10,
  parameter int PB_DEPTH   = 16,
  parameter int HIST_DEPTH = 16,
  parameter int ADDR_W     = 10,
  parameter int LFSR_W     = 23,
  parameter int LFSR_TAP   = 18
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bx_i,
  input  logic                      l1a_i,
  input  logic [NUM_CH*CH_W-1:0]    data_i,
  input  logic [NUM_CH*RAW_W-1:0]   raw_i,
  input  logic                      reg_we_i,
  input  logic [ADDR_W-1:0]         reg_addr_i,
  input  logic [REG_W-1:0]          reg_wdata_i,
  output logic [REG_W-1:0]          reg_rdata_o,
  output logic [NUM_CH*CH_W-1:0]    link_data_o
);
  localparam int ENT_W = NUM_CH * CH_W;
  localparam int WPC   = ENT_W / REG_W;
  localparam int PB_AW = $clog2(PB_DEPTH * WPC);
  localparam int HI_AW = $clog2(HIST_DEPTH * WPC);
  localparam int IDX_W = ADDR_W - 2;
  localparam int CH_AW = $clog2(NUM_CH);

  logic [2:0]                       mode_q;
  logic                             freeze_q;
  logic [CH_W-1:0]                  const_q;
  logic [NUM_CH-1:0][RAW_W-1:0]     raw_q;
  logic [ENT_W-1:0]                 link_q;
  logic [REG_W-1:0]                 rdata_q;

  logic [1:0]                       region;
  logic [IDX_W-1:0]                 idx;
  logic                             csr_we, ctrl_we, const_we, seed_we, pb_we, start;
  logic                             prbs_adv, play_adv, capture;
  logic [LFSR_W-1:0]                lfsr_state;
  logic [ENT_W-1:0]                 prbs_word, play_word, raw_word, const_word, sel;
  logic [REG_W-1:0]                 pb_rd, hist_rd, rd_d;

  // register decode
  assign region   = reg_addr_i[ADDR_W-1 -: 2];
  assign idx      = reg_addr_i[IDX_W-1:0];
  assign csr_we   = reg_we_i && (region == RG_CSR);
  assign ctrl_we  = csr_we && (idx == IDX_W'(CSR_CTRL));
  assign const_we = csr_we && (idx == IDX_W'(CSR_CONST));
  assign seed_we  = csr_we && (idx == IDX_W'(CSR_SEED));
  assign pb_we    = reg_we_i && (region == RG_PLAY);
  assign start    = ctrl_we && reg_wdata_i[CTRL_START_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= M_NORM;
      freeze_q <= 1'b0;
      const_q  <= '0;
    end else begin
      if (ctrl_we) begin
        mode_q   <= reg_wdata_i[2:0];
        freeze_q <= reg_wdata_i[CTRL_FRZ_BIT];
      end
      if (const_we) const_q <= reg_wdata_i[CH_W-1:0];
    end
  end

  // sources
  assign prbs_adv = bx_i && (mode_q == M_PRBS);
  assign play_adv = bx_i && (mode_q == M_PLAY);
  assign capture  = bx_i && l1a_i;

  lpm_prbs #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .LFSR_W(LFSR_W), .TAP(LFSR_TAP), .SLICE_STEP(3)
  ) u_prbs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .seed_we_i (seed_we),
    .seed_i    (reg_wdata_i[LFSR_W-1:0]),
    .adv_i     (prbs_adv),
    .state_o   (lfsr_state),
    .word_o    (prbs_word)
  );

  lpm_playback #(
    .ENT_W(ENT_W), .DEPTH(PB_DEPTH), .REG_W(REG_W)
  ) u_play (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (pb_we),
    .wr_addr_i (idx[PB_AW-1:0]),
    .wr_data_i (reg_wdata_i),
    .rd_addr_i (idx[PB_AW-1:0]),
    .rd_data_o (pb_rd),
    .start_i   (start),
    .adv_i     (play_adv),
    .ent_o     (play_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      raw_q <= '0;
    else if (capture) raw_q <= raw_i;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_raw
    assign raw_word[c*CH_W +: CH_W]   = raw_q[c][RAW_W-1 -: CH_W];
    assign const_word[c*CH_W +: CH_W] = const_q;
  end

  always_comb begin
    unique case (mode_q)
      M_CONST: sel = const_word;
      M_PRBS:  sel = prbs_word;
      M_PLAY:  sel = play_word;
      M_RAW:   sel = raw_word;
      default: sel = data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   link_q <= '0;
    else if (bx_i) link_q <= sel;
  end

  assign link_data_o = link_q;

  lpm_history #(
    .ENT_W(ENT_W), .DEPTH(HIST_DEPTH), .REG_W(REG_W)
  ) u_hist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (bx_i),
    .ent_i     (sel),
    .freeze_i  (freeze_q),
    .rd_addr_i (idx[HI_AW-1:0]),
    .rd_data_o (hist_rd)
  );

  // readback
  always_comb begin
    rd_d = '0;
    unique case (region)
      RG_CSR: begin
        if (idx == IDX_W'(CSR_CTRL)) begin
          rd_d[2:0]          = mode_q;
          rd_d[CTRL_FRZ_BIT] = freeze_q;
        end else if (idx == IDX_W'(CSR_CONST)) begin
          rd_d[CH_W-1:0] = const_q;
        end else if (idx == IDX_W'(CSR_SEED)) begin
          rd_d[LFSR_W-1:0] = lfsr_state;
        end
      end
      RG_PLAY: rd_d = pb_rd;
      RG_HIST: rd_d = hist_rd;
      default: rd_d[RAW_W-1:0] = raw_q[idx[CH_AW-1:0]];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_d;
  end

  assign reg_rdata_o = rdata_q;

  a_r2_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bx_i |=> $stable(link_data_o));
  a_r3_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bx_i && (mode_q == M_NORM) |=> link_data_o == $past(data_i));
  a_r4_const_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bx_i && (mode_q == M_CONST) |=> link_data_o == {NUM_CH{$past(const_q)}});
  a_r10_raw_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bx_i && l1a_i) |=> $stable(raw_q));
  a_r10_raw_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bx_i && l1a_i |=> raw_q == $past(raw_i));
endmodule

// File: tb/link_pattern_mux_tb.sv
`timescale 1ns/1ps
module link_pattern_mux_tb;
  localparam int NCH = 32, RW = 10, PBD = 16, HD = 16, ENT = 256, WPC = 8;

  logic clk = 1'b0, rst_n = 1'b0, bx = 1'b0, l1a = 1'b0, we = 1'b0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [ENT-1:0] data = '0;
  logic [NCH*RW-1:0] raw = '0;
  logic [31:0] rdata;
  logic [ENT-1:0] link;

  always #2.5 clk = ~clk;

  link_pattern_mux u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bx_i(bx), .l1a_i(l1a), .data_i(data), .raw_i(raw),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .link_data_o(link)
  );

  int n_chk = 0, n_fail = 0;
  bit bx_on = 0, done = 0;

  task automatic check(input bit ok, input string tag, input logic [ENT-1:0] act,
                       input logic [ENT-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_mode, m_ptr;
  bit m_freeze, m_restart;
  logic [7:0] m_const;
  logic [22:0] m_lfsr;
  logic [31:0] m_pb [PBD][WPC];
  logic [ENT-1:0] m_hist [$];
  logic [RW-1:0] m_raw [NCH];
  logic [ENT-1:0] m_out;
  logic [31:0] m_rdata;
  string m_otag = "R1", m_rtag = "R1";

  function automatic logic [ENT-1:0] prbs_word(input logic [22:0] s);
    logic [ENT-1:0] v;
    for (int c = 0; c < NCH; c++)
      for (int b = 0; b < 8; b++) v[c*8+b] = s[(3*c+b) % 23];
    return v;
  endfunction

  function automatic logic [31:0] model_read(input logic [9:0] a);
    int i;
    i = a[7:0];
    case (a[9:8])
      2'd0: begin
        if (i == 0) return {22'd0, 1'b0, m_freeze, 5'd0, m_mode[2:0]};
        if (i == 1) return {24'd0, m_const};
        if (i == 2) return {9'd0, m_lfsr};
        return 32'd0;
      end
      2'd1: return m_pb[(i % 128) / 8][i % 8];
      2'd2: begin
        if ((i % 128) / 8 < m_hist.size()) return m_hist[(i % 128) / 8][(i % 8)*32 +: 32];
        return 32'd0;
      end
      default: return {22'd0, m_raw[i % 32]};
    endcase
  endfunction

  function automatic string read_tag(input logic [9:0] a);
    case (a[9:8])
      2'd0: return (a[7:0] == 1) ? "R4" : (a[7:0] == 2) ? "R5" : "R11";
      2'd1: return "R6";
      2'd2: return m_freeze ? "R9" : "R8";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_ptr = 0; m_freeze = 0; m_restart = 0; m_const = '0;
      m_lfsr = 23'h7FFFFF; m_hist.delete(); m_out = '0; m_rdata = '0;
      for (int n = 0; n < PBD; n++) for (int w = 0; w < WPC; w++) m_pb[n][w] = '0;
      for (int c = 0; c < NCH; c++) m_raw[c] = '0;
      m_otag = "R1"; m_rtag = "R1";
    end else begin
      logic [ENT-1:0] v;
      m_rdata = model_read(addr);
      m_rtag  = read_tag(addr);
      if (bx) begin
        case (m_mode)
          1: for (int c = 0; c < NCH; c++) v[c*8 +: 8] = m_const;
          2: v = prbs_word(m_lfsr);
          3: for (int w = 0; w < WPC; w++) v[w*32 +: 32] = m_pb[m_ptr][w];
          4: for (int c = 0; c < NCH; c++) v[c*8 +: 8] = m_raw[c][9:2];
          default: v = data;
        endcase
        case (m_mode)
          1: m_otag = "R4";
          2: m_otag = "R5";
          3: m_otag = m_restart ? "R7" : "R6";
          4: m_otag = "R10";
          default: m_otag = "R3";
        endcase
        if (m_mode == 2) m_lfsr = {m_lfsr[21:0], m_lfsr[22] ^ m_lfsr[17]};
        if (m_mode == 3) begin m_ptr = (m_ptr + 1) % PBD; m_restart = 0; end
        if (!m_freeze) begin
          m_hist.push_front(v);
          if (m_hist.size() > HD) void'(m_hist.pop_back());
        end
        if (l1a) for (int c = 0; c < NCH; c++) m_raw[c] = raw[c*RW +: RW];
        m_out = v;
      end else begin
        m_otag = "R2";
      end
      if (we) begin
        if (addr[9:8] == 2'd0) begin
          if (addr[7:0] == 0) begin
            m_mode = wdata[2:0]; m_freeze = wdata[8];
            if (wdata[9]) begin m_ptr = 0; m_restart = 1; end
          end else if (addr[7:0] == 1) m_const = wdata[7:0];
          else if (addr[7:0] == 2 && wdata[22:0] != 0) m_lfsr = wdata[22:0];
        end else if (addr[9:8] == 2'd1) begin
          m_pb[(addr[6:0]) / 8][addr[2:0]] = wdata;
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  initial forever begin
    @(negedge clk);
    if (rst_n && !done) begin
      check(link === m_out, m_otag, link, m_out);
      check(rdata === m_rdata, m_rtag, {224'd0, rdata}, {224'd0, m_rdata});
    end
  end

  // crossing generator with random gaps, including back-to-back strobes
  initial begin
    int gap;
    gap = 0;
    forever begin
      @(negedge clk);
      if (bx_on && gap == 0) begin
        bx = 1'b1;
        for (int i = 0; i < 8; i++) data[i*32 +: 32] = $urandom;
        for (int i = 0; i < 10; i++) raw[i*32 +: 32] = $urandom;
        l1a = ($urandom % 4) == 0;
        gap = $urandom_range(0, 3);
      end else begin
        bx = 1'b0;
        l1a = 1'b0;
        if (gap > 0) gap--;
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a);
    @(negedge clk);
    addr = a;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(link == '0, "R1", link, '0);
    check(rdata == 32'd0, "R1", {224'd0, rdata}, '0);
    rd(10'h002);
    check(rdata == 32'h7FFFFF, "R1", {224'd0, rdata}, {224'd0, 32'h7FFFFF});
    rd(10'h105);
    check(rdata == 32'd0, "R1", {224'd0, rdata}, '0);
    rd(10'h200);
    check(rdata == 32'd0, "R1", {224'd0, rdata}, '0);
    rd(10'h000);

    bx_on = 1;
    idle(40);                         // R3 forwarding
    wr(10'h001, 32'hA5);
    wr(10'h000, 32'd1);               // R4 constant
    idle(30);
    wr(10'h001, 32'h3C);
    idle(20);
    rd(10'h001);

    wr(10'h002, 32'h001234);          // R5 seed then stream
    wr(10'h000, 32'd2);
    idle(60);
    wr(10'h002, 32'd0);               // zero seed ignored
    rd(10'h002);
    idle(20);
    wr(10'h000, 32'd6);               // unused code forwards data
    idle(20);
    wr(10'h000, 32'd2);               // stream resumes from held state
    idle(20);

    for (int i = 0; i < PBD * WPC; i++) wr(10'h100 + 10'(i), $urandom);
    for (int i = 0; i < 8; i++) rd(10'h100 + 10'(i * 13));
    wr(10'h000, 32'h203);             // R7 start with playback mode
    idle(100);                        // past the wrap
    wr(10'h000, 32'd0);
    idle(20);
    wr(10'h000, 32'd3);               // R6 pointer continues
    idle(30);
    wr(10'h000, 32'h203);             // R7 restart
    idle(30);

    wr(10'h000, 32'd4);               // R10 raw mode
    idle(40);
    for (int c = 0; c < NCH; c++) rd(10'h300 + 10'(c));

    wr(10'h000, 32'h100);             // R9 freeze
    idle(30);
    for (int i = 0; i < HD * WPC; i++) rd(10'h200 + 10'(i));
    rd(10'h000);
    wr(10'h000, 32'd0);               // resume recording
    idle(20);
    for (int i = 0; i < 24; i++) rd(10'h200 + 10'(i * 5));  // R8 moving history
    wr(10'h000, 32'd7);
    idle(20);

    bx_on = 0;
    idle(5);
    done = 1;
    summary();
    $finish;
  end
endmodule